// File: doc/BRIEF.md
# Rook Line-of-Sight Attack Map

This block turns a complete snapshot of a chessboard into a map of rook attacks along ranks and files, with no clock and no stored state. Each of the 64 squares arrives as a one-hot group of 13 signals naming its occupant. For every square and each of the four orthogonal directions, the block reports whether a white rook, and separately a black rook, can reach that square from that side.

Each directional flag is a sum of products. Product term k is true when the k-th square out from the target holds a rook of the given colour and all squares nearer to the target are empty. Any occupied square stops the line, whatever the piece and whatever its colour. A per-colour summary vector ORs the four directions. The block sits in a move-generation or evaluation datapath that needs the full map within the same cycle the board changes.

Top module: `rookAttackMap`

## Requirements
- R1: Square index is rank*8 + file, with file a = 0 and rank 1 = 0. Square s uses input bits [s*13 +: 13]. Bit 0 means empty. Bits 1..6 are white pawn, knight, bishop, rook, queen and king. Bits 7..12 are the same six pieces in black, so bit 4 is a white rook and bit 10 is a black rook. An all-empty board drives every output to zero.
- R2: All outputs are combinational functions of the current board only. No clock or state exists, and a board change shows up at the outputs without any clock edge.
- R3: A rook of a colour on the square directly adjacent in a direction sets that colour's flag for that direction. North means higher rank, east means higher file.
- R4: A rook further along the line sets the flag when every square strictly between it and the target is empty.
- R5: Any non-empty square blocks the line beyond it. This holds for either colour and any piece kind, including a rook of the other colour.
- R6: The contents of the target square do not affect its own flags. A rook never reports its own square as attacked.
- R7: A square on the board edge in a given direction has that direction's flag at 0.
- R8: White flags respond only to white rooks, and black flags only to black rooks. Queens and other pieces never create an attack.
- R9: Each colour's any-direction vector is the bitwise OR of that colour's four direction vectors.
- R10: A square on the top rank is attacked from the south by a rook on the bottom rank of the same file when the six squares between them are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| board | input | 832 | One-hot occupant code per square, 13 bits per square |
| whiteFromNorth | output | 64 | White rook reaches square from higher ranks |
| whiteFromSouth | output | 64 | White rook reaches square from lower ranks |
| whiteFromEast | output | 64 | White rook reaches square from higher files |
| whiteFromWest | output | 64 | White rook reaches square from lower files |
| whiteAny | output | 64 | OR of the four white direction vectors |
| blackFromNorth | output | 64 | Black rook reaches square from higher ranks |
| blackFromSouth | output | 64 | Black rook reaches square from lower ranks |
| blackFromEast | output | 64 | Black rook reaches square from higher files |
| blackFromWest | output | 64 | Black rook reaches square from lower files |
| blackAny | output | 64 | OR of the four black direction vectors |

## Verification
The hardest case to reach from the ports is the full-length product term: a seven-square line with six empty squares between a rook and an edge square. Random boards with realistic density almost never produce it. Directed near-empty boards place single rooks on corners and edges to reach it, and a board filled entirely with rooks drives every edge square at once. Random boards, checked against a ray-walking reference, then cover mixed blocking by pieces of both colours.

// File: rtl/rookmap_pkg.sv
package rookmap_pkg;
  localparam int BOARD_DIM  = 8;
  localparam int NUM_SQ     = BOARD_DIM * BOARD_DIM;
  localparam int KIND_BITS  = 13;
  localparam int KIND_EMPTY = 0;
  localparam int KIND_WROOK = 4;
  localparam int KIND_BROOK = 10;
  localparam int NUM_DIRS   = 4;
  localparam int NUM_COLS   = 2;

  typedef enum logic [1:0] {
    DIR_NORTH = 2'd0,
    DIR_SOUTH = 2'd1,
    DIR_EAST  = 2'd2,
    DIR_WEST  = 2'd3
  } rayDir_e;

  function automatic int rankStep(rayDir_e d);
    return (d == DIR_NORTH) ? 1 : (d == DIR_SOUTH) ? -1 : 0;
  endfunction

  function automatic int fileStep(rayDir_e d);
    return (d == DIR_EAST) ? 1 : (d == DIR_WEST) ? -1 : 0;
  endfunction
endpackage

// File: rtl/sqDecode.sv
module sqDecode
  import rookmap_pkg::*;
#(
  parameter int SQUARES  = NUM_SQ,
  parameter int GROUP_W  = KIND_BITS,
  parameter int EMPTY_B  = KIND_EMPTY,
  parameter int WROOK_B  = KIND_WROOK,
  parameter int BROOK_B  = KIND_BROOK
) (
  input  logic [SQUARES*GROUP_W-1:0] board,
  output logic [SQUARES-1:0]         emptySq,
  output logic [SQUARES-1:0]         whiteRook,
  output logic [SQUARES-1:0]         blackRook
);
  for (genvar sq = 0; sq < SQUARES; sq++) begin : g_sq
    assign emptySq[sq]   = board[sq*GROUP_W + EMPTY_B];
    assign whiteRook[sq] = board[sq*GROUP_W + WROOK_B];
    assign blackRook[sq] = board[sq*GROUP_W + BROOK_B];
  end
endmodule

// File: rtl/rayScan.sv
module rayScan
  import rookmap_pkg::*;
#(
  parameter int      DIM = BOARD_DIM,
  parameter rayDir_e DIR = DIR_NORTH
) (
  input  logic [DIM*DIM-1:0] emptySq,
  input  logic [DIM*DIM-1:0] rook,
  output logic [DIM*DIM-1:0] attack
);
  localparam int SQUARES = DIM * DIM;
  localparam int SQ_W    = $clog2(SQUARES);
  localparam int DR      = rankStep(DIR);
  localparam int DF      = fileStep(DIR);

  // Sum of products: term k = empty(1..k-1) & rook(k), expanded per square.
  always_comb begin
    logic hit;
    logic clear;
    int   r;
    int   f;
    logic [SQ_W-1:0] idx;
    attack = '0;
    for (int sq = 0; sq < SQUARES; sq++) begin
      hit   = 1'b0;
      clear = 1'b1;
      for (int k = 1; k < DIM; k++) begin
        r = sq / DIM + k * DR;
        f = sq % DIM + k * DF;
        if (r >= 0 && r < DIM && f >= 0 && f < DIM) begin
          idx   = SQ_W'(r * DIM + f);
          hit   = hit | (clear & rook[idx]);
          clear = clear & emptySq[idx];
        end
      end
      attack[sq] = hit;
    end
  end

  // Per-square checks against the neighbour one step out along the line.
  for (genvar sq = 0; sq < SQUARES; sq++) begin : g_chk
    localparam int NR = sq / DIM + DR;
    localparam int NF = sq % DIM + DF;
    if (NR >= 0 && NR < DIM && NF >= 0 && NF < DIM) begin : g_nb
      localparam int NB = NR * DIM + NF;
      always_comb begin
        a_r3_adjacent_rook: assert (!rook[NB] || attack[sq]);
        a_r4_line_recurrence: assert (attack[sq] == (rook[NB] | (emptySq[NB] & attack[NB])));
        a_r5_blocker_stops: assert (emptySq[NB] || rook[NB] || !attack[sq]);
        a_r8_needs_own_rook: assert ((|rook) || !attack[sq]);
      end
    end
  end
endmodule

// File: rtl/rookAttackMap.sv
module rookAttackMap
  import rookmap_pkg::*;
(
  input  logic [NUM_SQ*KIND_BITS-1:0] board,
  output logic [NUM_SQ-1:0]           whiteFromNorth,
  output logic [NUM_SQ-1:0]           whiteFromSouth,
  output logic [NUM_SQ-1:0]           whiteFromEast,
  output logic [NUM_SQ-1:0]           whiteFromWest,
  output logic [NUM_SQ-1:0]           whiteAny,
  output logic [NUM_SQ-1:0]           blackFromNorth,
  output logic [NUM_SQ-1:0]           blackFromSouth,
  output logic [NUM_SQ-1:0]           blackFromEast,
  output logic [NUM_SQ-1:0]           blackFromWest,
  output logic [NUM_SQ-1:0]           blackAny
);
  logic [NUM_SQ-1:0] emptySq;
  logic [NUM_COLS-1:0][NUM_SQ-1:0] rookPlane;
  logic [NUM_COLS-1:0][NUM_DIRS-1:0][NUM_SQ-1:0] rayMap;

  sqDecode #(
    .SQUARES(NUM_SQ), .GROUP_W(KIND_BITS), .EMPTY_B(KIND_EMPTY),
    .WROOK_B(KIND_WROOK), .BROOK_B(KIND_BROOK)
  ) i_sqDecode (
    .board    (board),
    .emptySq  (emptySq),
    .whiteRook(rookPlane[0]),
    .blackRook(rookPlane[1])
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      rayScan #(.DIM(BOARD_DIM), .DIR(rayDir_e'(d))) i_rayScan (
        .emptySq(emptySq),
        .rook   (rookPlane[c]),
        .attack (rayMap[c][d])
      );
    end
  end

  assign whiteFromNorth = rayMap[0][DIR_NORTH];
  assign whiteFromSouth = rayMap[0][DIR_SOUTH];
  assign whiteFromEast  = rayMap[0][DIR_EAST];
  assign whiteFromWest  = rayMap[0][DIR_WEST];
  assign blackFromNorth = rayMap[1][DIR_NORTH];
  assign blackFromSouth = rayMap[1][DIR_SOUTH];
  assign blackFromEast  = rayMap[1][DIR_EAST];
  assign blackFromWest  = rayMap[1][DIR_WEST];
  assign whiteAny = whiteFromNorth | whiteFromSouth | whiteFromEast | whiteFromWest;
  assign blackAny = blackFromNorth | blackFromSouth | blackFromEast | blackFromWest;

  // R6: a lone rook never marks its own square.
  always_comb begin
    a_r6_not_self: assert (!($countones(rookPlane[0]) == 1 && (|(rookPlane[0] & whiteAny))));
  end
endmodule

// File: tb/test_rookAttackMap.sv
`timescale 1ns/1ps
module test_rookAttackMap;
  localparam int SQ = 64;
  localparam int KB = 13;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [SQ*KB-1:0] board;
  logic [SQ-1:0] wN, wS, wE, wW, wA, bN, bS, bE, bW, bA;
  int total = 0;
  int bad = 0;

  rookAttackMap i_rookAttackMap (
    .board(board),
    .whiteFromNorth(wN), .whiteFromSouth(wS), .whiteFromEast(wE), .whiteFromWest(wW),
    .whiteAny(wA),
    .blackFromNorth(bN), .blackFromSouth(bS), .blackFromEast(bE), .blackFromWest(bW),
    .blackAny(bA)
  );

  task automatic check(input string tag, input logic [SQ-1:0] got, input logic [SQ-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clearBoard();
    for (int s = 0; s < SQ; s++) board[s*KB +: KB] = 13'd1;
  endtask

  task automatic putPiece(input int s, input int kind);
    board[s*KB +: KB] = 13'd1 << kind;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [SQ-1:0] refDir(input int rookBit, input int dr, input int df);
    logic [SQ-1:0] res = '0;
    for (int s = 0; s < SQ; s++) begin
      int r = s / 8 + dr;
      int f = s % 8 + df;
      while (r >= 0 && r < 8 && f >= 0 && f < 8) begin
        if (board[(r*8+f)*KB + rookBit]) begin res[s] = 1'b1; break; end
        if (!board[(r*8+f)*KB]) break;
        r += dr;
        f += df;
      end
    end
    return res;
  endfunction

  task automatic compareAll(input string tag);
    logic [SQ-1:0] xN, xS, xE, xW, yN, yS, yE, yW;
    xN = refDir(4, 1, 0);  xS = refDir(4, -1, 0);
    xE = refDir(4, 0, 1);  xW = refDir(4, 0, -1);
    yN = refDir(10, 1, 0); yS = refDir(10, -1, 0);
    yE = refDir(10, 0, 1); yW = refDir(10, 0, -1);
    check({tag, " R3/R4/R5 wN"}, wN, xN);
    check({tag, " R3/R4/R5 wS"}, wS, xS);
    check({tag, " R3/R4/R5 wE"}, wE, xE);
    check({tag, " R3/R4/R5 wW"}, wW, xW);
    check({tag, " R9 wAny"}, wA, xN | xS | xE | xW);
    check({tag, " R8 bN"}, bN, yN);
    check({tag, " R8 bS"}, bS, yS);
    check({tag, " R8 bE"}, bE, yE);
    check({tag, " R8 bW"}, bW, yW);
    check({tag, " R9 bAny"}, bA, yN | yS | yE | yW);
  endtask

  task automatic testEmpty();
    clearBoard(); settle();
    check("R1 empty wAny", wA, '0);
    check("R1 empty bAny", bA, '0);
    compareAll("R1 empty");
  endtask

  task automatic testTopRank();
    clearBoard(); putPiece(0, 4); settle();
    check("R10 a8 from south", 64'(wS[56]), 64'(1));
    check("R10 column a from south", wS & 64'h0101010101010100, 64'h0101010101010100);
    compareAll("R10");
  endtask

  task automatic testAdjacent();
    clearBoard(); putPiece(27, 4); settle();
    check("R3 north of d3", 64'(wN[19]), 64'(1));
    check("R3 south of d5", 64'(wS[35]), 64'(1));
    check("R3 east of c4", 64'(wE[26]), 64'(1));
    check("R3 west of e4", 64'(wW[28]), 64'(1));
    check("R6 own square", 64'(wA[27]), 64'(0));
    compareAll("R3");
  endtask

  task automatic testBlock();
    clearBoard(); putPiece(0, 4); putPiece(24, 7); settle();
    check("R5 blocker square hit", 64'(wS[24]), 64'(1));
    check("R5 beyond black pawn", 64'(wS[32]), 64'(0));
    check("R5 a8 blocked", 64'(wS[56]), 64'(0));
    compareAll("R5 black");
    putPiece(24, 2); settle();
    check("R5 beyond white knight", 64'(wS[32]), 64'(0));
    putPiece(24, 10); settle();
    check("R5 beyond black rook", 64'(wS[32]), 64'(0));
    compareAll("R5 mixed");
  endtask

  task automatic testSelf();
    clearBoard(); putPiece(27, 4); putPiece(28, 4); settle();
    check("R6 d4 from east", 64'(wE[27]), 64'(1));
    check("R6 e4 from west", 64'(wW[28]), 64'(1));
    check("R6 c4 from east", 64'(wE[26]), 64'(1));
    check("R6 f4 from west", 64'(wW[29]), 64'(1));
    compareAll("R6");
  endtask

  task automatic testEdge();
    for (int s = 0; s < SQ; s++) putPiece(s, 4);
    settle();
    check("R7 top rank north", wN, 64'h00FFFFFFFFFFFFFF);
    check("R7 bottom rank south", wS, 64'hFFFFFFFFFFFFFF00);
    check("R7 file h east", wE, 64'h7F7F7F7F7F7F7F7F);
    check("R7 file a west", wW, 64'hFEFEFEFEFEFEFEFE);
    check("R8 black none", bA, '0);
  endtask

  task automatic testColour();
    clearBoard(); putPiece(0, 10); putPiece(7, 5); putPiece(63, 11); settle();
    check("R8 white none", wA, '0);
    check("R8 black a8 south", 64'(bS[56]), 64'(1));
    check("R8 black h1 west", 64'(bW[7]), 64'(1));
    check("R8 queen no attack g8", 64'(wE[62] | bE[62]), 64'(0));
    compareAll("R8");
  endtask

  task automatic testNoClock();
    clearBoard(); putPiece(63, 4);
    #1;
    check("R2 immediate h1 north", 64'(wN[7]), 64'(1));
    putPiece(31, 7);
    #1;
    check("R2 immediate blocked", 64'(wN[7]), 64'(0));
  endtask

  task automatic testRandom();
    for (int n = 0; n < 200; n++) begin
      for (int s = 0; s < SQ; s++) begin
        int pick = $urandom_range(0, 24);
        putPiece(s, (pick > 12) ? 0 : pick);
      end
      settle();
      compareAll("R4 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearBoard();
    testEmpty();
    testTopRank();
    testAdjacent();
    testBlock();
    testSelf();
    testEdge();
    testColour();
    testNoClock();
    testRandom();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule